// File: doc/BRIEF.md
# Single-Level Page Table Walker

The walker turns a 20-bit virtual page number into an 18-bit physical page number. It reads one entry from a flat page table in memory. The table holds one 32-bit word for every virtual page, so the page number is a direct index into it and no tag is compared. A base register gives the physical byte address where the table starts. A TLB, or any other requester, hands the walker a page number and an access type. The walker fetches the entry and answers with a one-cycle response pulse that carries either a translation or one of two faults.

Each entry has a present flag, a modified flag and a write-permission flag. A store to a present, writable page that is not yet marked modified makes the walker write the entry back with the modified flag set before it answers. The walker serves one request at a time. Its memory port is one request line held until a single-cycle acknowledge, and the same port is used for reads and writes.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready_o is 1 and busy_o, rsp_valid_o and mem_req_o are 0.
- R2: The entry fetch address on mem_addr_o is the base register plus the virtual page number times 4, wrapped to 30 bits.
- R3: A fetched entry with bit 31 (present) set answers a read request with rsp_ppn_o equal to entry bits [17:0] and no fault flag. Bits [28:18] do not affect the result, and neither does bit 29 on a read.
- R4: A fetched entry with bit 31 clear gives rsp_page_fault_o = 1 with the response, rsp_ppn_o = 0, and no memory write.
- R5: A write request to a present entry with bit 29 (writable) clear gives rsp_prot_fault_o = 1, rsp_ppn_o = 0, and no memory write.
- R6: A write request to a present, writable entry with bit 30 (modified) clear causes exactly one memory write, to the fetch address, of the fetched word with bit 30 set. This write comes before the response, and the response then carries the translation.
- R7: A write request to an entry that already has bit 30 set causes no memory write and answers with the translation.
- R8: Only one request is held at a time. From acceptance until the response, req_ready_o is 0 and busy_o is 1. rsp_valid_o is a single-cycle pulse, after which the walker is idle again.
- R9: A base register write while busy_o is 1 has no effect. The next walk still uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_we_i | input | 1 | Base register write strobe |
| base_data_i | input | 30 | New table base, physical byte address |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vpn_i | input | 20 | Virtual page number |
| req_write_i | input | 1 | Access is a store |
| busy_o | output | 1 | Walk in progress |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_ppn_o | output | 18 | Physical page number, 0 on a fault |
| rsp_page_fault_o | output | 1 | Entry not present |
| rsp_prot_fault_o | output | 1 | Store to a read-only page |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 30 | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rvalid_i | input | 1 | Memory acknowledge, read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
Loads and stores are each run against present, absent, read-only, clean and already-modified entries. This separates the translation path from the two fault paths and from the write-back path. Entries with junk in the reserved bits show that only the low 18 bits reach the answer. A base near the top of the 30-bit space shows that the fetch address wraps rather than saturates. A base write issued in the middle of a walk checks that the base register is held against change while a walk is running.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  parameter int unsigned VA_W  = 32;
  parameter int unsigned PA_W  = 30;
  parameter int unsigned OFF_W = 12;
  parameter int unsigned PTE_W = 32;

  localparam int unsigned VPN_W  = VA_W - OFF_W;
  localparam int unsigned PPN_W  = PA_W - OFF_W;
  localparam int unsigned IDX_SH = $clog2(PTE_W / 8);

  localparam int unsigned PRESENT_BIT = PTE_W - 1;
  localparam int unsigned DIRTY_BIT   = PTE_W - 2;
  localparam int unsigned WRITE_BIT   = PTE_W - 3;

  typedef enum logic [1:0] {FLT_NONE, FLT_PAGE, FLT_PROT} fault_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WB, ST_RESP} walk_st_e;

  typedef struct packed {
    logic             present;
    logic             dirty;
    logic             writable;
    logic [PPN_W-1:0] ppn;
  } pte_t;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg
  import ptw_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            idle_i,
  input  logic [PA_W-1:0] data_i,
  output logic [PA_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             base_o <= '0;
    else if (we_i && idle_i) base_o <= data_i;
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [PA_W-1:0]  base_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [PA_W-1:0]  addr_o
);
  localparam int unsigned SUM_W = (VPN_W + IDX_SH > PA_W) ? VPN_W + IDX_SH : PA_W;
  logic [SUM_W-1:0] off_ext, sum;
  always_comb begin
    off_ext = SUM_W'({vpn_i, {IDX_SH{1'b0}}});
    sum     = SUM_W'(base_i) + off_ext;
    addr_o  = sum[PA_W-1:0];
  end
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] word_i,
  input  logic             is_write_i,
  output pte_t             pte_o,
  output fault_e           fault_o,
  output logic             need_wb_o,
  output logic [PTE_W-1:0] wb_word_o
);
  always_comb begin
    pte_o.present  = word_i[PRESENT_BIT];
    pte_o.dirty    = word_i[DIRTY_BIT];
    pte_o.writable = word_i[WRITE_BIT];
    pte_o.ppn      = word_i[PPN_W-1:0];

    if (!pte_o.present)                   fault_o = FLT_PAGE;
    else if (is_write_i && !pte_o.writable) fault_o = FLT_PROT;
    else                                  fault_o = FLT_NONE;

    need_wb_o = (fault_o == FLT_NONE) && is_write_i && !pte_o.dirty;
    wb_word_o = word_i;
    wb_word_o[DIRTY_BIT] = 1'b1;
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic             req_write_i,
  output logic             idle_o,
  output logic [VPN_W-1:0] vpn_o,
  output logic             write_o,
  input  pte_t             pte_i,
  input  fault_e           fault_i,
  input  logic             need_wb_i,
  input  logic [PTE_W-1:0] wb_word_i,
  input  logic             mem_rvalid_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  output logic             rsp_valid_o,
  output logic [PPN_W-1:0] rsp_ppn_o,
  output logic             rsp_page_fault_o,
  output logic             rsp_prot_fault_o
);
  walk_st_e         state_q;
  fault_e           fault_q;
  logic [PPN_W-1:0] ppn_q;
  logic [PTE_W-1:0] wb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fault_q <= FLT_NONE;
      ppn_q   <= '0;
      wb_q    <= '0;
      vpn_o   <= '0;
      write_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vpn_o   <= req_vpn_i;
          write_o <= req_write_i;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (mem_rvalid_i) begin
          fault_q <= fault_i;
          wb_q    <= wb_word_i;
          ppn_q   <= (fault_i == FLT_NONE) ? pte_i.ppn : '0;
          state_q <= need_wb_i ? ST_WB : ST_RESP;
        end
        ST_WB:   if (mem_rvalid_i) state_q <= ST_RESP;
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    idle_o           = (state_q == ST_IDLE);
    mem_req_o        = (state_q == ST_FETCH) || (state_q == ST_WB);
    mem_we_o         = (state_q == ST_WB);
    mem_wdata_o      = (state_q == ST_WB) ? wb_q : '0;
    rsp_valid_o      = (state_q == ST_RESP);
    rsp_ppn_o        = ppn_q;
    rsp_page_fault_o = rsp_valid_o && (fault_q == FLT_PAGE);
    rsp_prot_fault_o = rsp_valid_o && (fault_q == FLT_PROT);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_we_i,
  input  logic [PA_W-1:0]  base_data_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic             req_write_i,
  output logic             busy_o,
  output logic             rsp_valid_o,
  output logic [PPN_W-1:0] rsp_ppn_o,
  output logic             rsp_page_fault_o,
  output logic             rsp_prot_fault_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  logic             idle;
  logic [PA_W-1:0]  base_q;
  logic [VPN_W-1:0] vpn_q;
  logic             write_q;
  pte_t             pte;
  fault_e           fault;
  logic             need_wb;
  logic [PTE_W-1:0] wb_word;

  ptw_base_reg u_base (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(base_we_i), .idle_i(idle),
    .data_i(base_data_i), .base_o(base_q)
  );

  ptw_addr_gen u_addr (.base_i(base_q), .vpn_i(vpn_q), .addr_o(mem_addr_o));

  ptw_pte_check u_check (
    .word_i(mem_rdata_i), .is_write_i(write_q), .pte_o(pte), .fault_o(fault),
    .need_wb_o(need_wb), .wb_word_o(wb_word)
  );

  ptw_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_vpn_i(req_vpn_i), .req_write_i(req_write_i),
    .idle_o(idle), .vpn_o(vpn_q), .write_o(write_q),
    .pte_i(pte), .fault_i(fault), .need_wb_i(need_wb), .wb_word_i(wb_word),
    .mem_rvalid_i(mem_rvalid_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .rsp_valid_o(rsp_valid_o), .rsp_ppn_o(rsp_ppn_o),
    .rsp_page_fault_o(rsp_page_fault_o), .rsp_prot_fault_o(rsp_prot_fault_o)
  );

  assign req_ready_o = idle;
  assign busy_o      = !idle;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic [PPN_W-1:0] rsp_ppn_o,
  input logic             rsp_page_fault_o,
  input logic             rsp_prot_fault_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [PA_W-1:0]  mem_addr_o,
  input logic [PTE_W-1:0] mem_wdata_o,
  input logic             mem_rvalid_i,
  input logic             base_we_i,
  input logic [PA_W-1:0]  base_q
);
  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));
  p_fault_no_ppn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_page_fault_o || rsp_prot_fault_o) |-> rsp_ppn_o == '0);
  p_fault_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_page_fault_o && rsp_prot_fault_o));
  p_wb_sets_dirty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[DIRTY_BIT]);
  p_rsp_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && !busy_o);
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !rsp_valid_o);
  p_base_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && base_we_i |=> $stable(base_q));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_ppn_o(rsp_ppn_o),
  .rsp_page_fault_o(rsp_page_fault_o), .rsp_prot_fault_o(rsp_prot_fault_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_rvalid_i(mem_rvalid_i),
  .base_we_i(base_we_i), .base_q(base_q)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [29:0] base_data = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_vpn = '0;
  logic        req_ready, busy, rsp_valid, pf, prf;
  logic [17:0] rsp_ppn;
  logic        mem_req, mem_we, mem_rvalid = 1'b0;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;

  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem [256];
  int          rd_cnt = 0, wr_cnt = 0;
  logic [29:0] rd_addr, wr_addr;
  logic [31:0] wr_data;
  logic        got_pf, got_prf;
  logic [17:0] got_ppn;
  int          wr_before_rsp;

  always #5 clk = ~clk;

  ptw_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .base_we_i(base_we), .base_data_i(base_data),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vpn_i(req_vpn),
    .req_write_i(req_write), .busy_o(busy), .rsp_valid_o(rsp_valid),
    .rsp_ppn_o(rsp_ppn), .rsp_page_fault_o(pf), .rsp_prot_fault_o(prf),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    mem_rvalid <= mem_req && !mem_rvalid;
    if (mem_req && !mem_rvalid) begin
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wr_addr <= mem_addr; wr_data <= mem_wdata; wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[9:2]];
        rd_addr <= mem_addr; rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(logic p, logic d, logic w, logic [10:0] junk, logic [17:0] ppn);
    return {p, d, w, junk, ppn};
  endfunction

  function automatic logic [29:0] ent_addr(logic [29:0] b, logic [19:0] v);
    return b + {v, 2'b00};
  endfunction

  task automatic set_base(input logic [29:0] b);
    @(negedge clk); base_we = 1'b1; base_data = b;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic walk(input logic [19:0] vpn, input logic wr, input logic poke_base, input logic [29:0] poke_val);
    int t;
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    req_valid = 1'b1; req_vpn = vpn; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R8 busy after accept", {busy, req_ready}, 2'b10);
    if (poke_base) begin
      base_we = 1'b1; base_data = poke_val;
      @(negedge clk); base_we = 1'b0;
    end
    t = 0;
    while (!rsp_valid && t < 50) begin
      chk(busy && !req_ready, "R8 busy during walk", {busy, req_ready}, 2'b10);
      @(negedge clk); t++;
    end
    wr_before_rsp = wr_cnt;
    got_pf = pf; got_prf = prf; got_ppn = rsp_ppn;
    chk(rsp_valid, "R8 response arrives", rsp_valid, 1);
    @(negedge clk);
    chk(!rsp_valid && !busy && req_ready, "R8 single pulse then idle", {rsp_valid, busy, req_ready}, 3'b001);
  endtask

  task automatic t_reset;
    chk(req_ready && !busy && !rsp_valid && !mem_req, "R1 reset state",
        {req_ready, busy, rsp_valid, mem_req}, 4'b1000);
  endtask

  task automatic t_read_hit;
    logic [29:0] a;
    set_base(30'h100);
    a = ent_addr(30'h100, 20'd5);
    mem[a[9:2]] = mk_pte(1, 0, 0, 11'h5A5, 18'h2BCDE);
    walk(20'd5, 1'b0, 1'b0, '0);
    chk(rd_addr == a, "R2 fetch address", rd_addr, a);
    chk(got_ppn == 18'h2BCDE && !got_pf && !got_prf, "R3 translation", got_ppn, 18'h2BCDE);
    chk(wr_cnt == 0, "R7 no write on read", wr_cnt, 0);
  endtask

  task automatic t_invalid;
    logic [29:0] a;
    a = ent_addr(30'h100, 20'd9);
    mem[a[9:2]] = mk_pte(0, 1, 1, 11'h0, 18'h11111);
    walk(20'd9, 1'b1, 1'b0, '0);
    chk(got_pf && !got_prf, "R4 page fault flag", {got_pf, got_prf}, 2'b10);
    chk(got_ppn == 0, "R4 no ppn", got_ppn, 0);
    chk(wr_cnt == 0, "R4 no write", wr_cnt, 0);
  endtask

  task automatic t_prot;
    logic [29:0] a;
    a = ent_addr(30'h100, 20'd12);
    mem[a[9:2]] = mk_pte(1, 0, 0, 11'h0, 18'h22222);
    walk(20'd12, 1'b1, 1'b0, '0);
    chk(got_prf && !got_pf, "R5 protection fault", {got_pf, got_prf}, 2'b01);
    chk(got_ppn == 0, "R5 no ppn", got_ppn, 0);
    chk(wr_cnt == 0, "R5 no write", wr_cnt, 0);
    walk(20'd12, 1'b0, 1'b0, '0);
    chk(got_ppn == 18'h22222 && !got_prf, "R3 read of read-only page", got_ppn, 18'h22222);
  endtask

  task automatic t_wb_clean;
    logic [29:0] a;
    logic [31:0] w;
    a = ent_addr(30'h100, 20'd20);
    w = mk_pte(1, 0, 1, 11'h3, 18'h3F00F);
    mem[a[9:2]] = w;
    walk(20'd20, 1'b1, 1'b0, '0);
    chk(wr_before_rsp == 1, "R6 one write before response", wr_before_rsp, 1);
    chk(wr_addr == a, "R6 write address", wr_addr, a);
    chk(wr_data == (w | 32'h4000_0000), "R6 write data", wr_data, w | 32'h4000_0000);
    chk(got_ppn == 18'h3F00F && !got_pf && !got_prf, "R6 translation", got_ppn, 18'h3F00F);
  endtask

  task automatic t_wb_dirty;
    logic [29:0] a;
    a = ent_addr(30'h100, 20'd20);
    walk(20'd20, 1'b1, 1'b0, '0);
    chk(wr_cnt == 0, "R7 no write when modified", wr_cnt, 0);
    chk(got_ppn == 18'h3F00F, "R7 translation", got_ppn, 18'h3F00F);
  endtask

  task automatic t_addr_wrap;
    logic [29:0] a;
    set_base(30'h3FFF_FFF0);
    a = ent_addr(30'h3FFF_FFF0, 20'd8);
    mem[a[9:2]] = mk_pte(1, 0, 1, 11'h0, 18'h00777);
    walk(20'd8, 1'b0, 1'b0, '0);
    chk(rd_addr == 30'h10, "R2 wrapped address", rd_addr, 30'h10);
    chk(got_ppn == 18'h00777, "R3 wrapped translation", got_ppn, 18'h00777);
    set_base(30'h0);
    a = ent_addr(30'h0, 20'hFFFFF);
    mem[a[9:2]] = mk_pte(1, 1, 1, 11'h7FF, 18'h3FFFF);
    walk(20'hFFFFF, 1'b1, 1'b0, '0);
    chk(rd_addr == 30'h3F_FFFC, "R2 top vpn address", rd_addr, 30'h3F_FFFC);
    chk(got_ppn == 18'h3FFFF && wr_cnt == 0, "R7 top vpn modified", got_ppn, 18'h3FFFF);
  endtask

  task automatic t_base_busy;
    logic [29:0] a;
    set_base(30'h200);
    a = ent_addr(30'h200, 20'd3);
    mem[a[9:2]] = mk_pte(1, 0, 0, 11'h0, 18'h01234);
    walk(20'd3, 1'b0, 1'b1, 30'h2000);
    a = ent_addr(30'h200, 20'd4);
    mem[a[9:2]] = mk_pte(1, 0, 0, 11'h0, 18'h05678);
    walk(20'd4, 1'b0, 1'b0, '0);
    chk(rd_addr == a, "R9 base unchanged by busy write", rd_addr, a);
    chk(got_ppn == 18'h05678, "R9 translation with old base", got_ppn, 18'h05678);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_invalid();
    t_prot();
    t_wb_clean();
    t_wb_dirty();
    t_addr_wrap();
    t_base_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule